// File: doc/BRIEF.md
# NTSC Scanline and Field Sequencer

This block produces the horizontal and vertical timing of one non-interlaced NTSC composite field. It is clocked at the pixel rate, where one scanline is 400 ticks and equals 227.5 cycles of the 3.579545 MHz colour subcarrier. On every tick it reports which signal level the composite output should carry: sync, blank, colour burst or active picture. It also raises a pixel-request strobe while picture data is needed, and pulses to mark the start of each line and of each field.

A field runs in four stages. Top blank lines come first, then the picture lines, then bottom blank lines, and then a vertical interval of half-lines. That interval holds short-pulse and broad-pulse half-lines in place of a single vertical sync level. Blank lines keep their horizontal sync and burst. A downstream pixel fetcher uses the strobe to pace its reads. A colour converter and DAC use the level code to choose what they drive.

Top module: `ntsc_field_seq`

## Requirements
- R1: While `rst` is high, all outputs are low (level code 00). On the first clock edge after `rst` falls, the outputs present tick 0 of a new field.
- R2: The level code is 00 for blank, 01 for sync, 10 for burst and 11 for active. Each full line is 400 ticks laid out in this order: sync 29, blank 7, burst 18, blank 40, a 256-tick picture window, and blank 50.
- R3: `pix_req` is high exactly on the 256 picture-window ticks of picture lines, and only there the level code is 11.
- R4: A field starts with 35 top blank lines, continues with 192 picture lines, and then has 27 bottom blank lines.
- R5: On blank lines the picture window carries level 00, while sync and burst keep their R2 positions.
- R6: After the bottom blank lines come 6 short half-lines of 200 ticks each: 15 ticks of sync, then 185 ticks of blank.
- R7: The next 6 half-lines are broad: 171 ticks of sync, then 29 ticks of blank.
- R8: Six more short half-lines follow, and then a new field begins. One field therefore lasts 105200 ticks.
- R9: `line_start` is high on the first tick of every line and every half-line. `field_start` is high only on the first tick of the first top blank line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rst | input | 1 | Synchronous active-high reset to field start |
| level | output | 2 | Level code for this tick |
| pix_req | output | 1 | Picture data request |
| line_start | output | 1 | First tick of a line or half-line |
| field_start | output | 1 | First tick of a field |

## Verification
All outputs are registered, so the value for field tick k appears one clock after the state for tick k is formed. Tick 0 is visible after the first rising edge that sees `rst` low. A reset asserted mid-field clears the outputs on the next edge. The bench keeps a field index that starts at zero when reset is released. It compares all four outputs against a behavioural model at every falling edge, half a cycle after the edge that updated them. It runs across one field wrap, applies a reset in the middle of the next field, and follows it back into the picture lines.

// File: rtl/ntsc_seq_pkg.sv
package ntsc_seq_pkg;
  typedef enum logic [1:0] {
    LVL_BLANK  = 2'b00,
    LVL_SYNC   = 2'b01,
    LVL_BURST  = 2'b10,
    LVL_ACTIVE = 2'b11
  } level_t;

  typedef enum logic [2:0] {
    PH_TOP, PH_PIC, PH_BOT, PH_EQ_A, PH_BROAD, PH_EQ_B
  } phase_t;
endpackage

// File: rtl/nts_tick_ctr.sv
module nts_tick_ctr #(
  parameter int LINE_T = 400,
  parameter int TW     = $clog2(LINE_T)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          half,
  output logic [TW-1:0] tick,
  output logic          last
);
  localparam logic [TW-1:0] FULL_END = TW'(LINE_T - 1);
  localparam logic [TW-1:0] HALF_END = TW'(LINE_T / 2 - 1);

  assign last = half ? (tick == HALF_END) : (tick == FULL_END);

  always_ff @(posedge clk) begin
    if (rst)       tick <= '0;
    else if (last) tick <= '0;
    else           tick <= tick + 1'b1;
  end

  AST_HALF_BOUND: assert property (@(posedge clk) disable iff (rst)
    half |-> tick <= HALF_END); // R6
endmodule

// File: rtl/nts_vert_ctr.sv
module nts_vert_ctr
  import ntsc_seq_pkg::*;
#(
  parameter int TOP_L = 35,
  parameter int PIC_L = 192,
  parameter int BOT_L = 27,
  parameter int EQ_N  = 6,
  parameter int CW    = $clog2(TOP_L + PIC_L + BOT_L + EQ_N + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  output phase_t        phase,
  output logic [CW-1:0] cnt,
  output logic          half
);
  logic [CW-1:0] lim;
  phase_t        nxt;
  logic          done;

  always_comb begin
    case (phase)
      PH_TOP:  begin lim = CW'(TOP_L - 1); nxt = PH_PIC;   end
      PH_PIC:  begin lim = CW'(PIC_L - 1); nxt = PH_BOT;   end
      PH_BOT:  begin lim = CW'(BOT_L - 1); nxt = PH_EQ_A;  end
      PH_EQ_A: begin lim = CW'(EQ_N - 1);  nxt = PH_BROAD; end
      PH_BROAD:begin lim = CW'(EQ_N - 1);  nxt = PH_EQ_B;  end
      default: begin lim = CW'(EQ_N - 1);  nxt = PH_TOP;   end
    endcase
  end

  assign done = (cnt == lim);
  assign half = (phase == PH_EQ_A) || (phase == PH_BROAD) || (phase == PH_EQ_B);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_TOP;
      cnt   <= '0;
    end else if (adv) begin
      if (done) begin
        phase <= nxt;
        cnt   <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  AST_CNT_IN_PHASE: assert property (@(posedge clk) disable iff (rst)
    cnt <= lim); // R4
endmodule

// File: rtl/nts_level_dec.sv
module nts_level_dec
  import ntsc_seq_pkg::*;
#(
  parameter int TW       = 9,
  parameter int SYNC_T   = 29,
  parameter int BP1_T    = 7,
  parameter int BURST_T  = 18,
  parameter int BP2_T    = 40,
  parameter int PIC_T    = 256,
  parameter int EQ_SYNC  = 15,
  parameter int BRD_SYNC = 171
) (
  input  logic [TW-1:0] tick,
  input  phase_t        phase,
  output level_t        level,
  output logic          pix
);
  localparam logic [TW-1:0] E_SYNC  = TW'(SYNC_T);
  localparam logic [TW-1:0] E_BP1   = TW'(SYNC_T + BP1_T);
  localparam logic [TW-1:0] E_BURST = TW'(SYNC_T + BP1_T + BURST_T);
  localparam logic [TW-1:0] E_BP2   = TW'(SYNC_T + BP1_T + BURST_T + BP2_T);
  localparam logic [TW-1:0] E_PIC   = TW'(SYNC_T + BP1_T + BURST_T + BP2_T + PIC_T);
  localparam logic [TW-1:0] E_EQ    = TW'(EQ_SYNC);
  localparam logic [TW-1:0] E_BRD   = TW'(BRD_SYNC);

  always_comb begin
    level = LVL_BLANK;
    pix   = 1'b0;
    case (phase)
      PH_EQ_A, PH_EQ_B: if (tick < E_EQ)  level = LVL_SYNC;
      PH_BROAD:         if (tick < E_BRD) level = LVL_SYNC;
      default: begin
        if (tick < E_SYNC) level = LVL_SYNC;
        else if (tick >= E_BP1 && tick < E_BURST) level = LVL_BURST;
        else if (phase == PH_PIC && tick >= E_BP2 && tick < E_PIC) begin
          level = LVL_ACTIVE;
          pix   = 1'b1;
        end
      end
    endcase
  end
endmodule

// File: rtl/ntsc_field_seq.sv
module ntsc_field_seq
  import ntsc_seq_pkg::*;
#(
  parameter int SYNC_T   = 29,
  parameter int BP1_T    = 7,
  parameter int BURST_T  = 18,
  parameter int BP2_T    = 40,
  parameter int PIC_T    = 256,
  parameter int FP_T     = 50,
  parameter int TOP_L    = 35,
  parameter int PIC_L    = 192,
  parameter int BOT_L    = 27,
  parameter int EQ_N     = 6,
  parameter int EQ_SYNC  = 15,
  parameter int BRD_SYNC = 171
) (
  input  logic       clk,
  input  logic       rst,
  output logic [1:0] level,
  output logic       pix_req,
  output logic       line_start,
  output logic       field_start
);
  localparam int LINE_T = SYNC_T + BP1_T + BURST_T + BP2_T + PIC_T + FP_T;
  localparam int TW     = $clog2(LINE_T);
  localparam int CW     = $clog2(TOP_L + PIC_L + BOT_L + EQ_N + 1);
  localparam int RW     = $clog2(PIC_T + 2);

  logic [TW-1:0] tick;
  logic          last, half, pix_c;
  phase_t        phase;
  logic [CW-1:0] cnt;
  level_t        lvl_c;

  nts_tick_ctr #(.LINE_T(LINE_T), .TW(TW)) u_tick (
    .clk(clk), .rst(rst), .half(half), .tick(tick), .last(last)
  );

  nts_vert_ctr #(.TOP_L(TOP_L), .PIC_L(PIC_L), .BOT_L(BOT_L), .EQ_N(EQ_N), .CW(CW)) u_vert (
    .clk(clk), .rst(rst), .adv(last), .phase(phase), .cnt(cnt), .half(half)
  );

  nts_level_dec #(.TW(TW), .SYNC_T(SYNC_T), .BP1_T(BP1_T), .BURST_T(BURST_T),
                  .BP2_T(BP2_T), .PIC_T(PIC_T), .EQ_SYNC(EQ_SYNC), .BRD_SYNC(BRD_SYNC)) u_dec (
    .tick(tick), .phase(phase), .level(lvl_c), .pix(pix_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      level       <= LVL_BLANK;
      pix_req     <= 1'b0;
      line_start  <= 1'b0;
      field_start <= 1'b0;
    end else begin
      level       <= lvl_c;
      pix_req     <= pix_c;
      line_start  <= (tick == '0);
      field_start <= (tick == '0) && (phase == PH_TOP) && (cnt == '0);
    end
  end

  logic [RW-1:0] run_len;
  always_ff @(posedge clk) begin
    if (rst)          run_len <= '0;
    else if (pix_req) run_len <= run_len + 1'b1;
    else              run_len <= '0;
  end

  AST_FIELD_ON_LINE: assert property (@(posedge clk) disable iff (rst)
    field_start |-> line_start); // R9
  AST_LINE_OPENS_SYNC: assert property (@(posedge clk) disable iff (rst)
    line_start |-> level == LVL_SYNC); // R2
  AST_PIX_WITH_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    pix_req == (level == LVL_ACTIVE)); // R3
  AST_BURST_AFTER_BLANK: assert property (@(posedge clk) disable iff (rst)
    $rose(level == LVL_BURST) |-> $past(level) == LVL_BLANK); // R5
  AST_PIC_RUN_LEN: assert property (@(posedge clk) disable iff (rst)
    run_len <= RW'(PIC_T)); // R3
endmodule

// File: tb/tb_ntsc_field_seq.sv
module tb_ntsc_field_seq;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] level;
  logic       pix_req, line_start, field_start;

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;

  localparam int FIELD_T = 254 * 400 + 18 * 200;

  always #2 clk = ~clk;

  ntsc_field_seq dut (
    .clk(clk), .rst(rst), .level(level), .pix_req(pix_req),
    .line_start(line_start), .field_start(field_start)
  );

  // expected {field_start, line_start, pix_req, level[1:0]} for field tick idx
  function automatic logic [4:0] model(int idx);
    int k = idx % FIELD_T;
    logic fs = 0, ls = 0, px = 0;
    logic [1:0] lv = 2'b00;
    if (k < 254 * 400) begin
      int ln = k / 400;
      int t  = k % 400;
      ls = (t == 0);
      fs = (k == 0);
      if (t < 29) lv = 2'b01;
      else if (t >= 36 && t < 54) lv = 2'b10;
      else if (ln >= 35 && ln < 227 && t >= 94 && t < 350) begin
        lv = 2'b11;
        px = 1;
      end
    end else begin
      int v = k - 254 * 400;
      int h = v / 200;
      int t = v % 200;
      ls = (t == 0);
      if (h >= 6 && h < 12) lv = (t < 171) ? 2'b01 : 2'b00;
      else                  lv = (t < 15)  ? 2'b01 : 2'b00;
    end
    return {fs, ls, px, lv};
  endfunction

  function automatic string tag_of(int idx, logic [4:0] exp_v, logic [4:0] act_v);
    int k = idx % FIELD_T;
    if (exp_v[4:3] != act_v[4:3]) return "R9";
    if (exp_v[2] != act_v[2]) return "R3";
    if (k >= 254 * 400) begin
      int h = (k - 254 * 400) / 200;
      if (h < 6) return "R6";
      if (h < 12) return "R7";
      return "R8";
    end
    if (k / 400 < 35 || k / 400 >= 227) return "R5";
    if (k / 400 < 227 && k % 400 >= 94 && k % 400 < 350) return "R4";
    return "R2";
  endfunction

  task automatic compare(int idx);
    logic [4:0] act_v = {field_start, line_start, pix_req, level};
    logic [4:0] exp_v = model(idx);
    vectors++;
    if (act_v !== exp_v) begin
      errors++;
      if (errors <= 20)
        $display("FAIL %s tick %0d actual %b expected %b", tag_of(idx, exp_v, act_v), idx, act_v, exp_v);
    end
  endtask

  task automatic check_reset_state();
    vectors++;
    if ({field_start, line_start, pix_req, level} !== 5'b0) begin
      errors++;
      $display("FAIL R1 reset outputs actual %b expected 00000", {field_start, line_start, pix_req, level});
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check_reset_state();                 // R1
    rst = 1'b0;
    // one full field plus the wrap into the next (R2..R9, R8 field length)
    for (int i = 0; i < FIELD_T + 800; i++) begin
      @(negedge clk);
      compare(i);
    end
    // mid-field reset, then restart from field tick 0 (R1)
    rst = 1'b1;
    @(negedge clk);
    check_reset_state();
    @(negedge clk);
    check_reset_state();
    rst = 1'b0;
    for (int i = 0; i < 40 * 400; i++) begin
      @(negedge clk);
      compare(i);
    end
    finish_run();
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual running expected finished");
    finish_run();
  end
endmodule